// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block performs the sixteen data-processing operations of a 32-bit integer datapath, chosen by a 4-bit operation code. From the same inputs it derives the next negative, zero, carry and overflow flags. The caller supplies the first operand and a second operand that has already been shifted or rotated. It also supplies the shifter's carry-out, the current flag values and a set-flags control bit. The block returns the result, a destination-write enable, a flag-update enable and the flag values to commit.

The arithmetic is combinational. The whole answer is held in one output register stage with a valid/ready handshake on both sides. An operation is accepted when `in_valid` and `in_ready` are both high at a rising clock edge, and it appears on the output port on the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, every output holds its value and no new operation is accepted. Each accepted operation produces exactly one output transfer, and transfers keep their order.

Top module: `dp_alu`

## Requirements
- R1: Logical codes produce these results: 0 = op1 AND op2, 1 = op1 XOR op2, 8 = op1 AND op2, 9 = op1 XOR op2, 12 = op1 OR op2, 13 = op2, 14 = op1 AND NOT op2, 15 = NOT op2.
- R2: Arithmetic codes produce these results, all modulo 2^32: 2 = op1-op2, 3 = op2-op1, 4 = op1+op2, 5 = op1+op2+carry, 6 = op1-op2+carry-1, 7 = op2-op1+carry-1, 10 = op1-op2, 11 = op1+op2.
- R3: Codes 8 to 11 are compare-only operations. They drive `out_wr_en` low and `out_flag_we` high, whatever `in_set_flags` is. Every other code drives `out_wr_en` high.
- R4: `in_flags` and `out_flags` use the bit order {N,Z,C,V}, with bit 3 = N and bit 0 = V. When flags update, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R5: When a logical code (0, 1, 8, 9, 12 to 15) updates flags, C takes `in_shift_c` and V keeps its incoming value.
- R6: For codes 2 and 10, C = (op2 <= op1) unsigned, and V is set when the operands differ in sign and the result's sign differs from op1. Code 3 applies the same rules with op1 and op2 exchanged.
- R7: For codes 4, 5 and 11, C is the carry out of bit 31 of the full sum, including the incoming carry for code 5. V is set when both addends share a sign that the result does not.
- R8: For code 6, the subtrahend is the 33-bit value op2 - carry + 1. C = (subtrahend <= op1), and V follows the code-2 rule with op2. Code 7 applies the same rules with op1 and op2 exchanged.
- R9: With `in_set_flags` low, every code outside 8 to 11 drives `out_flag_we` low, and `out_flags` equals the accepted `in_flags`.
- R10: Each accepted operation yields exactly one output transfer, in order. While it waits for `out_ready`, the output holds still. `in_ready` is high exactly when the output register is empty or is draining.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_opcode | input | 4 | Operation code |
| in_set_flags | input | 1 | Request a flag update |
| in_op1 | input | 32 | First operand |
| in_op2 | input | 32 | Second operand, already shifted |
| in_shift_c | input | 1 | Shifter carry-out |
| in_flags | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Operation result |
| out_wr_en | output | 1 | Write result to destination |
| out_flag_we | output | 1 | Commit out_flags |
| out_flags | output | 4 | Next flags {N,Z,C,V} |

## Verification
The hardest conditions to reach from the ports are the carry boundaries of the borrow-with-carry operations. One is a subtrahend that reaches 2^32, which happens when op2 is all ones and the carry is clear. The other is the signed-overflow edges at 0x7FFFFFFF and 0x80000000. Random operands almost never land on these values. The stimulus therefore sweeps every code over all pairs drawn from {0, 0xFFFFFFFF, 0x80000000, 0x7FFFFFFF}, under both carry values and both set-flags values. Random operands follow, and `out_ready` is throttled so that results are held under back-pressure at the same time.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  localparam int FLAG_W = 4;

  function automatic logic op_is_compare(alu_op_e op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    return (op >= OP_SUB && op <= OP_RSC) || op == OP_CMP || op == OP_CMN;
  endfunction

endpackage

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/dp_alu_arith.sv
module dp_alu_arith
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           c_out,
  output logic           v_out
);

  localparam int XW = W + 1;

  logic          swap, is_add, use_c, keep_c;
  logic [W-1:0]  x, y;
  logic [XW-1:0] sum, subtr, diff;
  logic [W-1:0]  v_add_vec, v_sub_vec;

  always_comb begin
    swap   = (op == OP_RSB) || (op == OP_RSC);
    is_add = (op == OP_ADD) || (op == OP_ADC) || (op == OP_CMN);
    use_c  = (op == OP_ADC) || (op == OP_SBC) || (op == OP_RSC);
    x      = swap ? b : a;
    y      = swap ? a : b;
    keep_c = use_c ? cin : 1'b1;
    // sum carries one extra bit so the carry out of the top bit is visible
    sum    = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, use_c & cin};
    // subtrahend = y - c + 1, i.e. y + NOT c; plain subtract uses c = 1
    subtr  = {1'b0, y} + {{W{1'b0}}, ~keep_c};
    diff   = {1'b0, x} - subtr;
    res    = is_add ? sum[W-1:0] : diff[W-1:0];
    v_add_vec = (x ^ res) & (y ^ res);
    v_sub_vec = (x ^ res) & (~y ^ res);
    c_out  = is_add ? sum[W] : (subtr <= {1'b0, x});
    v_out  = is_add ? v_add_vec[W-1] : v_sub_vec[W-1];
  end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic           set_flags,
  input  logic [W-1:0]   res_logic,
  input  logic [W-1:0]   res_arith,
  input  logic           c_arith,
  input  logic           v_arith,
  input  logic           shift_c,
  input  alu_flags_t     flags_in,
  output logic [W-1:0]   result,
  output logic           wr_en,
  output logic           flag_we,
  output alu_flags_t     flags_out
);

  logic       arith, cmp_only;
  alu_flags_t fresh;

  always_comb begin
    arith    = op_is_arith(op);
    cmp_only = op_is_compare(op);
    result   = arith ? res_arith : res_logic;
    wr_en    = !cmp_only;
    flag_we  = cmp_only || set_flags;
    fresh.n  = result[W-1];
    fresh.z  = (result == '0);
    fresh.c  = arith ? c_arith : shift_c;
    fresh.v  = arith ? v_arith : flags_in.v;
    flags_out = flag_we ? fresh : flags_in;
  end

endmodule

// File: rtl/dp_alu_stage.sv
module dp_alu_stage #(
  parameter int P = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [P-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [P-1:0] m_data
);

  logic         full_q;
  logic [P-1:0] data_q;

  assign s_ready = !full_q || m_ready;
  assign m_valid = full_q;
  assign m_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (s_valid && s_ready) begin
      full_q <= 1'b1;
      data_q <= s_data;
    end else if (m_ready) begin
      full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_opcode,
  input  logic              in_set_flags,
  input  logic [W-1:0]      in_op1,
  input  logic [W-1:0]      in_op2,
  input  logic              in_shift_c,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_result,
  output logic              out_wr_en,
  output logic              out_flag_we,
  output logic [FLAG_W-1:0] out_flags
);

  localparam int PAY_W = W + 2 + FLAG_W;

  alu_op_e    op;
  alu_flags_t fin, fout;
  logic [W-1:0] r_logic, r_arith, r_sel;
  logic         c_ar, v_ar, wr_c, fwe_c;
  logic [PAY_W-1:0] pay_in, pay_out;

  assign op  = alu_op_e'(in_opcode);
  assign fin = alu_flags_t'(in_flags);

  dp_alu_logic #(.W(W)) u_logic (
    .op(op), .a(in_op1), .b(in_op2), .res(r_logic)
  );

  dp_alu_arith #(.W(W)) u_arith (
    .op(op), .a(in_op1), .b(in_op2), .cin(fin.c),
    .res(r_arith), .c_out(c_ar), .v_out(v_ar)
  );

  dp_alu_flags #(.W(W)) u_flags (
    .op(op), .set_flags(in_set_flags), .res_logic(r_logic),
    .res_arith(r_arith), .c_arith(c_ar), .v_arith(v_ar),
    .shift_c(in_shift_c), .flags_in(fin), .result(r_sel),
    .wr_en(wr_c), .flag_we(fwe_c), .flags_out(fout)
  );

  assign pay_in = {r_sel, wr_c, fwe_c, fout};

  dp_alu_stage #(.P(PAY_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(pay_in),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(pay_out)
  );

  assign out_result  = pay_out[PAY_W-1 -: W];
  assign out_wr_en   = pay_out[FLAG_W+1];
  assign out_flag_we = pay_out[FLAG_W];
  assign out_flags   = pay_out[FLAG_W-1:0];

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   in_opcode,
  input logic         in_set_flags,
  input logic [W-1:0] in_op1,
  input logic         in_shift_c,
  input logic [3:0]   in_flags,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_wr_en,
  input logic         out_flag_we,
  input logic [3:0]   out_flags
);

  logic take;
  logic is_cmp, is_logic;
  assign take     = in_valid && in_ready;
  assign is_cmp   = in_opcode[3:2] == 2'b10;
  assign is_logic = in_opcode == 4'h0 || in_opcode == 4'h1 || in_opcode == 4'h8 ||
                    in_opcode == 4'h9 || in_opcode >= 4'hC;

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_cmp |=> !out_wr_en && out_flag_we); // R3

  AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag_we |-> out_flags[3] == out_result[W-1] &&
                                 out_flags[2] == (out_result == '0)); // R4

  AST_LOGIC_CV: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_logic && (in_set_flags || is_cmp) |=>
      out_flags[1] == $past(in_shift_c) && out_flags[0] == $past(in_flags[0])); // R5

  AST_NO_SET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    take && !is_cmp && !in_set_flags |=>
      !out_flag_we && out_wr_en && out_flags == $past(in_flags)); // R9

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R10

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_flags) && $stable(out_wr_en) && $stable(out_flag_we)); // R10

  AST_NO_ACCEPT_WHEN_STUCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10

endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_opcode(in_opcode), .in_set_flags(in_set_flags), .in_op1(in_op1),
  .in_shift_c(in_shift_c), .in_flags(in_flags), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_wr_en(out_wr_en),
  .out_flag_we(out_flag_we), .out_flags(out_flags)
);

// File: tb/dp_alu_tb.sv
module dp_alu_tb;

  typedef struct packed {
    logic [31:0] res;
    logic        wr;
    logic        fwe;
    logic [3:0]  flg;
    logic [3:0]  op;
    logic        sf;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_set_flags = 1'b0, in_shift_c = 1'b0;
  logic [3:0]  in_opcode = '0, in_flags = '0, out_flags;
  logic [31:0] in_op1 = '0, in_op2 = '0, out_result;
  logic out_valid, out_ready = 1'b0, out_wr_en, out_flag_we;

  int checks = 0, fails = 0, sent = 0, got = 0;
  bit done_drv = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  dp_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_set_flags(in_set_flags), .in_op1(in_op1),
    .in_op2(in_op2), .in_shift_c(in_shift_c), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_flag_we(out_flag_we), .out_flags(out_flags)
  );

  function automatic string tag_of(logic [3:0] op, logic sf);
    if (!sf && op[3:2] != 2'b10) return "R9";
    case (op)
      4'h2, 4'h3, 4'hA: return "R6 (R2,R4)";
      4'h4, 4'h5, 4'hB: return "R7 (R2,R4)";
      4'h6, 4'h7:       return "R8 (R2,R4)";
      4'h8, 4'h9:       return "R3 (R1,R5)";
      default:          return "R1 (R4,R5)";
    endcase
  endfunction

  // Reference model, written from the requirement text
  function automatic exp_t model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                 logic sf, logic shc, logic [3:0] fl);
    exp_t e;
    longint unsigned ua = a, ub = b, t, sb;
    logic cin = fl[1];
    logic c = shc, v = fl[0];
    logic [31:0] r = '0;
    case (op)
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC: r = a | b;
      4'hD: r = b;
      4'hE: r = a & ~b;
      4'hF: r = ~b;
      4'h2, 4'hA: begin r = a - b; c = ub <= ua; v = (a[31] != b[31]) && (r[31] != a[31]); end
      4'h3: begin r = b - a; c = ua <= ub; v = (a[31] != b[31]) && (r[31] != b[31]); end
      4'h4, 4'hB: begin t = ua + ub; r = t[31:0]; c = t[32];
                   v = (a[31] == b[31]) && (r[31] != a[31]); end
      4'h5: begin t = ua + ub + cin; r = t[31:0]; c = t[32];
                   v = (a[31] == b[31]) && (r[31] != a[31]); end
      4'h6: begin sb = ub - cin + 1; t = ua - sb; r = t[31:0]; c = sb <= ua;
                   v = (a[31] != b[31]) && (r[31] != a[31]); end
      default: begin sb = ua - cin + 1; t = ub - sb; r = t[31:0]; c = sb <= ub;
                   v = (a[31] != b[31]) && (r[31] != b[31]); end
    endcase
    e.res = r;
    e.op  = op;
    e.sf  = sf;
    e.wr  = op[3:2] != 2'b10;
    e.fwe = (op[3:2] == 2'b10) || sf;
    e.flg = e.fwe ? {r[31], r == 32'h0, c, v} : fl;
    return e;
  endfunction

  task automatic send(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                      logic sf, logic shc, logic [3:0] fl);
    in_valid = 1'b1; in_opcode = op; in_op1 = a; in_op2 = b;
    in_set_flags = sf; in_shift_c = shc; in_flags = fl;
    do @(negedge clk); while (!in_ready);
    q.push_back(model(op, a, b, sf, shc, fl));
    sent++;
    @(posedge clk); #1;
    in_valid = 1'b0;
    if ($urandom_range(3) == 0) begin @(posedge clk); #1; end
  endtask

  // Monitor: compare on every output transfer
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        exp_t e;
        checks++;
        got++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R10: output transfer with no pending item (got res=%h exp none)", out_result);
        end else begin
          e = q.pop_front();
          if (out_result !== e.res || out_wr_en !== e.wr || out_flag_we !== e.fwe ||
              out_flags !== e.flg) begin
            fails++;
            $display("FAIL %s op=%h: got res=%h wr=%b fwe=%b flg=%b exp res=%h wr=%b fwe=%b flg=%b",
                     tag_of(e.op, e.sf), e.op, out_result, out_wr_en, out_flag_we, out_flags,
                     e.res, e.wr, e.fwe, e.flg);
          end
        end
      end
    end
  end

  // Back-pressure generator
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = ($urandom_range(2) != 0) || done_drv;
    end
  end

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: run hung (got %0d exp %0d transfers)", got, sent);
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] corner [4];
    corner[0] = 32'h0; corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;

    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R11: got out_valid=%b in_ready=%b exp 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;

    // Corner sweep: all codes, all corner pairs, both carries, both set-flags
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int k = 0; k < 4; k++)
            send(4'(op), corner[i], corner[j], k[1], k[0] ^ k[1],
                 {k[0], k[1], k[0], k[1] ^ 1'b1});

    // Random operands
    for (int n = 0; n < 600; n++)
      send(4'($urandom_range(15)), $urandom, $urandom, 1'($urandom_range(1)),
           1'($urandom_range(1)), 4'($urandom_range(15)));

    done_drv = 1;
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    // R10: one output per accepted input
    checks++;
    if (got != sent || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: got %0d transfers valid=%b exp %0d transfers valid=0", got, out_valid, sent);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule